// File: doc/BRIEF.md
# Fault-Aware Word Replication Controller

This controller sits between a processor-side request port and a backing memory that holds 72-bit coded words. Each word is 64 data bits plus 8 check bits. For every 64-bit word address it keeps a 2-bit fault class and a replica word address in an on-chip table. Test firmware loads that table through a configuration port once it has tested the memory at run time. On every access the controller looks up the class. The class decides whether the access goes to the primary word, to the replica word, or to both.

Writes are encoded with a single-error-correct, double-error-detect code before they reach the backing memory. Reads are checked and corrected. Words with no known defect rely on the code alone. A word with one hard defect is written twice, so the replica can stand in when a soft error lands on top of the hard one. A word with several defects is retired, and only its replica is used. The controller handles one request at a time. It accepts a request, runs the backing-memory accesses that the class needs, and then gives one response pulse.

Top module: `wrepl_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_valid` are 0. Every table entry reads as class error-free, so a request to a word that was never configured uses only its primary address.
- R2: Written data is stored as a 72-bit codeword. Bit 0 holds the overall parity. Check bits sit at positions 1, 2, 4, 8, 16, 32 and 64. The data bits fill the remaining positions, lowest bit first. Reading a word with no flipped bits returns the written data with `rsp_uncorr` = 0.
- R3: A single flipped bit at any of the 72 stored positions is corrected. The read returns the written data with `rsp_uncorr` = 0.
- R4: Class 2'b00 (error-free) uses only the primary address, with one backing access per request. Two flipped bits in the word give `rsp_uncorr` = 1.
- R5: A write to class 2'b01 (single-bit faulty) writes the same codeword to the primary word and then to the replica word. `rsp_valid` comes only after both backing writes have been accepted.
- R6: A read of class 2'b01 reads the primary word first. If that word is uncorrectable, the controller reads the replica and returns the replica's data with `rsp_uncorr` = 0. `rsp_uncorr` = 1 only when both copies are uncorrectable. If the primary word is correctable, only one read is made.
- R7: Class 2'b10 (multi-bit faulty) and class 2'b11 (reserved) send every read and write only to the replica address. The primary word is never accessed, and damage to it has no effect on results.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_write` and `mem_wdata` hold steady. Read data is taken from `mem_rdata` exactly RD_LAT cycles after the read handshake cycle.
- R9: Only one request is in flight at a time. `req_ready` is low from the cycle after a request is accepted through the cycle of its response. `rsp_valid` is a one-cycle pulse.
- R10: When `cfg_we` is high, the entry at `cfg_idx` takes the class and replica address given. The new entry governs every request accepted from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Fault-table write strobe |
| cfg_idx | input | AW | Word address whose entry is written |
| cfg_class | input | 2 | Fault class to store |
| cfg_repl | input | AW | Replica word address to store |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Primary word address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response pulse (read data or write done) |
| rsp_rdata | output | 64 | Read data |
| rsp_uncorr | output | 1 | Read could not be corrected |
| mem_valid | output | 1 | Backing access offered |
| mem_ready | input | 1 | Backing access accepted |
| mem_write | output | 1 | Backing access is a write |
| mem_addr | output | AW | Backing word address |
| mem_wdata | output | 72 | Codeword to store |
| mem_rdata | input | 72 | Codeword read, valid RD_LAT cycles after the handshake |

## Verification
The bench flips single bits at both edges of the codeword (the parity bit at 0 and bit 71) and at check-bit positions. A decoder that was off by one in its position mapping would return corrupted data there. For class 01 the bench damages the primary copy, then both copies. A controller that skipped the fallback read would raise `rsp_uncorr` too early, and one that read the replica unconditionally would add an extra read the bench counts. The backing model stalls at random and drives inverted data in every cycle except the one RD_LAT cycles after the handshake. Sampling in the wrong cycle therefore gives wrong data. A retired word has a sentinel left in its primary location, which must come through untouched. A word is also reclassified between requests to show that the table change takes effect at once.

// File: rtl/wrepl_pkg.sv
package wrepl_pkg;
  localparam int DW = 64;
  localparam int CW = 72;
  localparam int PW = 7;

  typedef enum logic [1:0] {
    FC_CLEAN  = 2'b00,
    FC_SINGLE = 2'b01,
    FC_MULTI  = 2'b10,
    FC_RSVD   = 2'b11
  } fclass_e;

  function automatic logic is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // spread data over non-power-of-two positions 1..CW-1, lowest bit first
  function automatic logic [CW-1:0] place_data(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p < CW; p++) begin
      if (!is_pow2(p)) begin
        c[p] = d[j];
        j++;
      end
    end
    return c;
  endfunction

  function automatic logic [DW-1:0] take_data(input logic [CW-1:0] c);
    logic [DW-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p < CW; p++) begin
      if (!is_pow2(p)) begin
        d[j] = c[p];
        j++;
      end
    end
    return d;
  endfunction

  // syndrome over all positions whose index has bit b set (check bits included)
  function automatic logic [PW-1:0] syndrome(input logic [CW-1:0] c);
    logic [PW-1:0] s;
    s = '0;
    for (int b = 0; b < PW; b++)
      for (int p = 1; p < CW; p++)
        if (p[b]) s[b] = s[b] ^ c[p];
    return s;
  endfunction

  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    logic [PW-1:0] s;
    c = place_data(d);
    s = syndrome(c);
    for (int b = 0; b < PW; b++) c[1 << b] = s[b];
    c[0] = ^c[CW-1:1];
    return c;
  endfunction
endpackage

// File: rtl/wrepl_secded_gen.sv
module wrepl_secded_gen
  import wrepl_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] cw_o
);
  assign cw_o = encode(data_i);
endmodule

// File: rtl/wrepl_secded_chk.sv
module wrepl_secded_chk
  import wrepl_pkg::*;
(
  input  logic [CW-1:0] cw_i,
  output logic [DW-1:0] data_o,
  output logic          uncorr_o
);
  logic [PW-1:0] syn;
  logic          par_odd;
  logic [CW-1:0] fixed;

  assign syn     = syndrome(cw_i);
  assign par_odd = ^cw_i;

  always_comb begin
    fixed    = cw_i;
    uncorr_o = 1'b0;
    if (par_odd) begin
      if (int'(syn) < CW) fixed[syn] = ~cw_i[syn];
      else                uncorr_o   = 1'b1;
    end else if (syn != '0) begin
      uncorr_o = 1'b1;
    end
  end

  assign data_o = take_data(fixed);
endmodule

// File: rtl/wrepl_fmap.sv
module wrepl_fmap #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [1:0]    wr_cls,
  input  logic [AW-1:0] wr_repl,
  input  logic [AW-1:0] rd_idx,
  output logic [1:0]    rd_cls,
  output logic [AW-1:0] rd_repl
);
  localparam int NENT = 1 << AW;

  logic [1:0]    cls_q [NENT];
  logic [AW-1:0] rep_q [NENT];

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cls_q[i] <= 2'b00;
        rep_q[i] <= '0;
      end else if (wr_en && wr_idx == AW'(i)) begin
        cls_q[i] <= wr_cls;
        rep_q[i] <= wr_repl;
      end
    end
  end

  assign rd_cls  = cls_q[rd_idx];
  assign rd_repl = rep_q[rd_idx];
endmodule

// File: rtl/wrepl_ctrl.sv
module wrepl_ctrl
  import wrepl_pkg::*;
#(
  parameter int AW     = 6,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_idx,
  input  logic [1:0]    cfg_class,
  input  logic [AW-1:0] cfg_repl,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [63:0]   req_wdata,
  output logic          rsp_valid,
  output logic [63:0]   rsp_rdata,
  output logic          rsp_uncorr,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [71:0]   mem_wdata,
  input  logic [71:0]   mem_rdata
);
  localparam int LW = $clog2(RD_LAT + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_WR, ST_RD, ST_WAIT, ST_RESP} st_e;

  st_e           st_q;
  logic [AW-1:0] addr_q, repl_q;
  logic [1:0]    cls_q;
  logic [CW-1:0] cw_q;
  logic          tgt_q;      // 0 primary, 1 replica
  logic          is_wr_q;
  logic [LW-1:0] lat_q;
  logic [63:0]   rdata_q;
  logic          uncorr_q;
  logic [1:0]    wr_cnt_q;   // backing writes of this request

  logic [1:0]    map_cls;
  logic [AW-1:0] map_repl;
  logic [CW-1:0] enc_cw;
  logic [DW-1:0] dec_data;
  logic          dec_uncorr;

  // named events
  logic accept, mem_hs, wr_hs, need_second, rd_sample, retry_rep;

  wrepl_fmap #(.AW(AW)) u_fmap (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_cls(cfg_class), .wr_repl(cfg_repl),
    .rd_idx(req_addr), .rd_cls(map_cls), .rd_repl(map_repl)
  );

  wrepl_secded_gen u_gen (.data_i(req_wdata), .cw_o(enc_cw));

  wrepl_secded_chk u_chk (.cw_i(mem_rdata), .data_o(dec_data), .uncorr_o(dec_uncorr));

  assign req_ready   = (st_q == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign mem_valid   = (st_q == ST_WR) || (st_q == ST_RD);
  assign mem_write   = (st_q == ST_WR);
  assign mem_addr    = tgt_q ? repl_q : addr_q;
  assign mem_wdata   = cw_q;
  assign mem_hs      = mem_valid && mem_ready;
  assign wr_hs       = mem_hs && mem_write;
  assign need_second = (cls_q == FC_SINGLE) && !tgt_q;
  assign rd_sample   = (st_q == ST_WAIT) && (lat_q == LW'(RD_LAT));
  assign retry_rep   = rd_sample && dec_uncorr && need_second;
  assign rsp_valid   = (st_q == ST_RESP);
  assign rsp_rdata   = rdata_q;
  assign rsp_uncorr  = uncorr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      repl_q   <= '0;
      cls_q    <= 2'b00;
      cw_q     <= '0;
      tgt_q    <= 1'b0;
      is_wr_q  <= 1'b0;
      lat_q    <= '0;
      rdata_q  <= '0;
      uncorr_q <= 1'b0;
      wr_cnt_q <= '0;
    end else begin
      if (wr_hs) wr_cnt_q <= wr_cnt_q + 2'd1;
      case (st_q)
        ST_IDLE: if (accept) begin
          addr_q   <= req_addr;
          repl_q   <= map_repl;
          cls_q    <= map_cls;
          cw_q     <= enc_cw;
          is_wr_q  <= req_write;
          tgt_q    <= map_cls[1];   // retired and reserved go straight to replica
          uncorr_q <= 1'b0;
          wr_cnt_q <= '0;
          st_q     <= req_write ? ST_WR : ST_RD;
        end
        ST_WR: if (mem_hs) begin
          if (need_second) tgt_q <= 1'b1;
          else             st_q  <= ST_RESP;
        end
        ST_RD: if (mem_hs) begin
          lat_q <= LW'(1);
          st_q  <= ST_WAIT;
        end
        ST_WAIT: begin
          if (retry_rep) begin
            tgt_q <= 1'b1;
            st_q  <= ST_RD;
          end else if (rd_sample) begin
            rdata_q  <= dec_data;
            uncorr_q <= dec_uncorr;
            st_q     <= ST_RESP;
          end else begin
            lat_q <= lat_q + LW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_CLEAN_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && cls_q == FC_CLEAN |-> mem_addr == addr_q); // R4
  AST_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && is_wr_q && cls_q == FC_SINGLE |-> wr_cnt_q == 2'd2); // R5
  AST_SOLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && is_wr_q && cls_q != FC_SINGLE |-> wr_cnt_q == 2'd1); // R5
  AST_FALLBACK_TRIED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !is_wr_q && rsp_uncorr && cls_q == FC_SINGLE |-> tgt_q); // R6
  AST_RETIRED_REPLICA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && cls_q[1] |-> mem_addr == repl_q); // R7
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)
                                && $stable(mem_wdata)); // R8
  AST_BUSY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
endmodule

// File: tb/tb_wrepl_ctrl.sv
`timescale 1ns/1ps
module tb_wrepl_ctrl;
  localparam int AW = 6;
  localparam int RD_LAT = 2;
  localparam int NW = 1 << AW;
  localparam logic [71:0] SENT = 72'h5A_C3C3_0F0F_F0F0_3C3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_idx = '0, cfg_repl = '0;
  logic [1:0] cfg_class = 2'b00;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_uncorr;
  logic [63:0] rsp_rdata;
  logic mem_valid, mem_write, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [71:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  wrepl_ctrl #(.AW(AW), .RD_LAT(RD_LAT)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_class(cfg_class), .cfg_repl(cfg_repl),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_uncorr(rsp_uncorr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [71:0] mem [NW];
  logic [1:0]    ecls [NW];
  logic [AW-1:0] erep [NW];
  logic [AW-1:0] cur_addr = '0;
  logic [AW-1:0] acc_a [$];
  logic          acc_w [$];
  logic [AW-1:0] rd_addr = '0;
  int rd_cnt = 0;
  logic [7:0] lfsr = 8'hA7;
  logic prev_stall = 1'b0, prev_wr = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [71:0] prev_wdata = '0;

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // backing memory: random stalls, data valid only RD_LAT cycles after handshake
  assign mem_ready = lfsr[0] | lfsr[2];
  assign mem_rdata = (rd_cnt == 1) ? mem[rd_addr] : ~mem[rd_addr];

  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      if (prev_stall)
        chk(mem_valid && mem_addr == prev_addr && mem_write == prev_wr && mem_wdata == prev_wdata,
            "R8 stall hold", {mem_valid, mem_write, mem_addr}, {1'b1, prev_wr, prev_addr});
      prev_stall <= mem_valid && !mem_ready;
      prev_addr  <= mem_addr;
      prev_wr    <= mem_write;
      prev_wdata <= mem_wdata;
      if (mem_valid && mem_ready) begin
        bit ok;
        acc_a.push_back(mem_addr);
        acc_w.push_back(mem_write);
        if (ecls[cur_addr] == 2'b00)  ok = (mem_addr == cur_addr);
        else if (ecls[cur_addr][1])   ok = (mem_addr == erep[cur_addr]);
        else                          ok = (mem_addr == cur_addr) || (mem_addr == erep[cur_addr]);
        chk(ok, "R4/R7 access target", mem_addr, cur_addr);
        if (mem_write) mem[mem_addr] = mem_wdata;
        else begin
          rd_addr <= mem_addr;
          rd_cnt  <= RD_LAT;
        end
      end else if (rd_cnt > 0) rd_cnt <= rd_cnt - 1;
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 100000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic cfg(input logic [AW-1:0] a, input logic [1:0] c, input logic [AW-1:0] r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = a; cfg_class = c; cfg_repl = r;
    @(negedge clk);
    cfg_we = 1'b0;
    ecls[a] = c; erep[a] = r;
  endtask

  task automatic do_req(input logic w, input logic [AW-1:0] a, input logic [63:0] d,
                        output logic [63:0] q, output logic u);
    @(negedge clk);
    acc_a.delete(); acc_w.delete(); cur_addr = a;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 busy after accept", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    q = rsp_rdata; u = rsp_uncorr;
    @(negedge clk);
    chk(!rsp_valid, "R9 single response pulse", rsp_valid, 0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
    logic [63:0] q; logic u;
    do_req(1'b1, a, d, q, u);
  endtask

  task automatic rd_exp(input logic [AW-1:0] a, input logic [63:0] d, input logic u_exp,
                        input int nrd, input string tag);
    logic [63:0] q; logic u;
    do_req(1'b0, a, d, q, u);
    chk(u == u_exp, {tag, " uncorr flag"}, u, u_exp);
    if (!u_exp) chk(q == d, {tag, " data"}, q, d);
    chk(acc_a.size() == nrd, {tag, " read count"}, acc_a.size(), nrd);
  endtask

  initial begin
    logic [63:0] pats [4];
    int bits [8];
    for (int i = 0; i < NW; i++) begin mem[i] = SENT; ecls[i] = 2'b00; erep[i] = '0; end
    pats[0] = 64'h0; pats[1] = '1; pats[2] = 64'h0123_4567_89AB_CDEF; pats[3] = 64'hAAAA_5555_F00F_0FF0;
    bits[0] = 0; bits[1] = 1; bits[2] = 2; bits[3] = 3; bits[4] = 37; bits[5] = 64; bits[6] = 70; bits[7] = 71;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_valid, "R1 reset outputs",
        {req_ready, rsp_valid, mem_valid}, 3'b100);

    // R1 unconfigured word is error-free: one write at the primary
    wr(7, 64'hDEAD_BEEF_0000_0007);
    chk(acc_a.size() == 1 && acc_a[0] == 7, "R1 default class primary", acc_a[0], 7);
    rd_exp(7, 64'hDEAD_BEEF_0000_0007, 1'b0, 1, "R1 default read");

    cfg(1, 2'b00, 33);
    cfg(2, 2'b01, 34);
    cfg(3, 2'b10, 35);
    cfg(4, 2'b11, 36);

    // R2 clean round trips
    for (int i = 0; i < 4; i++) begin
      wr(1, pats[i]);
      rd_exp(1, pats[i], 1'b0, 1, "R2 clean");
    end

    // R3 single flips at edges and check positions
    for (int i = 0; i < 8; i++) begin
      wr(1, pats[2] ^ 64'(i));
      mem[1][bits[i]] = ~mem[1][bits[i]];
      rd_exp(1, pats[2] ^ 64'(i), 1'b0, 1, "R3 single flip");
    end

    // R4 double flip on error-free word
    wr(1, pats[3]);
    mem[1][5] = ~mem[1][5]; mem[1][40] = ~mem[1][40];
    rd_exp(1, pats[3], 1'b1, 1, "R4 double flip");

    // R5 dual write, primary then replica
    wr(2, 64'h1111_2222_3333_4444);
    chk(acc_a.size() == 2 && acc_a[0] == 2 && acc_a[1] == 34 && acc_w[0] && acc_w[1],
        "R5 write order", {acc_a[0], acc_a[1]}, {6'd2, 6'd34});
    chk(mem[2] == mem[34], "R5 same codeword", mem[34], mem[2]);

    // R6 fallbacks
    rd_exp(2, 64'h1111_2222_3333_4444, 1'b0, 1, "R6 clean primary");
    mem[2][9] = ~mem[2][9];
    rd_exp(2, 64'h1111_2222_3333_4444, 1'b0, 1, "R6 correctable primary");
    mem[2][20] = ~mem[2][20];
    rd_exp(2, 64'h1111_2222_3333_4444, 1'b0, 2, "R6 replica fallback");
    chk(acc_a[0] == 2 && acc_a[1] == 34, "R6 fallback order", {acc_a[0], acc_a[1]}, {6'd2, 6'd34});
    mem[34][0] = ~mem[34][0]; mem[34][66] = ~mem[34][66];
    rd_exp(2, 64'h1111_2222_3333_4444, 1'b1, 2, "R6 both copies bad");

    // R7 retired and reserved classes
    wr(3, 64'hCAFE_0003_CAFE_0003);
    chk(mem[3] == SENT, "R7 primary untouched class 10", mem[3], SENT);
    mem[3][4] = ~mem[3][4]; mem[3][11] = ~mem[3][11];
    rd_exp(3, 64'hCAFE_0003_CAFE_0003, 1'b0, 1, "R7 class 10 read");
    wr(4, 64'hFACE_0004_FACE_0004);
    chk(mem[4] == SENT, "R7 primary untouched class 11", mem[4], SENT);
    rd_exp(4, 64'hFACE_0004_FACE_0004, 1'b0, 1, "R7 class 11 read");

    // R10 reclassify between requests
    wr(6, 64'hAAAA_0006_0000_0001);
    cfg(6, 2'b10, 38);
    wr(6, 64'hBBBB_0006_0000_0002);
    chk(acc_a.size() == 1 && acc_a[0] == 38, "R10 retarget write", acc_a[0], 38);
    rd_exp(6, 64'hBBBB_0006_0000_0002, 1'b0, 1, "R10 replica read");
    cfg(6, 2'b00, 38);
    rd_exp(6, 64'hAAAA_0006_0000_0001, 1'b0, 1, "R10 back to primary");

    repeat (4) @(negedge clk);
    report();
  end
endmodule